// File: doc/BRIEF.md
# Width-Aware Status Flag Unit

This block holds the processor status byte of a CPU core that can run its accumulator and index registers at either 8 or 16 bits. It also holds a separate emulation bit. The status byte keeps eight flags: negative, overflow, accumulator-size, index-size, decimal, interrupt-disable, zero and carry. The instruction decoder updates these flags through a single command port. Each command is one of the following:

- a masked clear or a masked set of status bits;
- a set or clear of one flag chosen by its bit index;
- a swap of the carry and emulation bits;
- a compare, which writes the negative, zero and carry flags.

A compare runs at 8 or 16 bits, as the index-size flag selects.

The datapath reads the current flags and two width selects straight from the registers. The width selects decide whether accumulator and index operations work on 8 or 16 bits. While the emulation bit is set, both sizes are held at 8 bits, and the index-size bit is reported as a break flag.

Top module: `sfu_top`

## Requirements
- R1: After reset the status byte reads 0x30 and the emulation bit reads 1. The status bit positions are N=7, V=6, M=5, X=4, D=3, I=2, Z=1, C=0.
- R2: With `cmd_valid` high, code 1 clears every status bit that is set in `cmd_arg`, and code 2 sets every status bit that is set in `cmd_arg`.
- R3: `acc_wide` is 1 exactly when M is 0. `idx_wide` is 1 exactly when X is 0 and the emulation bit is 0.
- R4: `brk_flag` is 1 when the emulation bit is 1 and status bit 4 is 1, and is 0 in native mode.
- R5: Code 5 swaps the carry flag and the emulation bit. Whenever the emulation bit is 1, M and X read 1, including after a masked clear.
- R6: Code 6 compares `cmp_reg` with `cmp_mem`. When X is 1, it uses the low 8 bits and takes N from bit 7 of the difference. When X is 0, it uses all 16 bits and takes N from bit 15. Z is set when the difference is zero, and C is set when `cmp_reg` is greater than or equal to `cmp_mem` at that width. No other flag changes.
- R7: The flags and width selects change on the same clock edge that accepts the command. For example, after code 2 with bit 4 set, `idx_wide` reads 0 right after that edge.
- R8: Code 4 sets, and code 3 clears, the single status bit whose index is `cmd_arg[2:0]`. Other bits do not change, apart from the forcing rule of R5.
- R9: When `cmd_valid` is low, or the code is 0, the status byte and the emulation bit do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 3 | 0 idle, 1 masked clear, 2 masked set, 3 clear one bit, 4 set one bit, 5 swap carry/emulation, 6 compare |
| cmd_arg | input | 8 | Bit mask for codes 1 and 2, bit index in [2:0] for codes 3 and 4 |
| cmp_reg | input | 16 | Register operand of a compare |
| cmp_mem | input | 16 | Memory operand of a compare |
| status | output | 8 | Current status byte |
| emu | output | 1 | Emulation bit |
| acc_wide | output | 1 | 1 selects a 16-bit accumulator |
| idx_wide | output | 1 | 1 selects 16-bit index registers |
| brk_flag | output | 1 | Break flag as reported in emulation mode |

## Verification
The assertions check the following on every cycle:
- M and X are held at 1 while in emulation;
- idle cycles leave the state unchanged;
- a masked set or clear reaches every selected bit;
- the swap really exchanges carry and emulation;
- the compare carry follows a plain magnitude comparison at the width in force.

Only the bench's scenarios show the rest. These include the exact value of the status byte along a sequence of commands, such as the reset value and the move from emulation into 16-bit native mode and back. They also include the compare cases whose result depends on the width: operands whose low bytes are equal but whose full values differ. Finally, the bench shows that the index width switches to 8 bits on the same edge that sets X.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;

  localparam int unsigned B_NEG  = 7;
  localparam int unsigned B_OVF  = 6;
  localparam int unsigned B_ASZ  = 5;
  localparam int unsigned B_ISZ  = 4;
  localparam int unsigned B_DEC  = 3;
  localparam int unsigned B_IRQ  = 2;
  localparam int unsigned B_ZERO = 1;
  localparam int unsigned B_CARRY = 0;

  localparam logic [FLAG_W-1:0] RESET_FLAGS = 8'h30;
  localparam logic [FLAG_W-1:0] EMU_FORCE   = 8'h30;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_CLRM  = 3'd1,
    CMD_SETM  = 3'd2,
    CMD_BCLR  = 3'd3,
    CMD_BSET  = 3'd4,
    CMD_XCHG  = 3'd5,
    CMD_CMP   = 3'd6
  } sfu_cmd_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
  } cmp_flags_t;
endpackage

// File: rtl/sfu_compare.sv
module sfu_compare
  import sfu_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned NW = BYTE_W
) (
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] mem_val,
  input  logic         narrow,
  output cmp_flags_t   flags
);
  localparam int unsigned WE  = W + 1;
  localparam int unsigned NWE = NW + 1;

  logic [WE-1:0]  diff_w;
  logic [NWE-1:0] diff_n;

  always_comb begin
    diff_w = {1'b0, reg_val} - {1'b0, mem_val};
    diff_n = {1'b0, reg_val[NW-1:0]} - {1'b0, mem_val[NW-1:0]};
    if (narrow) begin
      flags.neg   = diff_n[NW-1];
      flags.zero  = (diff_n[NW-1:0] == '0);
      flags.carry = ~diff_n[NW];
    end else begin
      flags.neg   = diff_w[W-1];
      flags.zero  = (diff_w[W-1:0] == '0);
      flags.carry = ~diff_w[W];
    end
  end
endmodule

// File: rtl/sfu_next.sv
module sfu_next
  import sfu_pkg::*;
#(
  parameter int unsigned FW = FLAG_W
) (
  input  logic [FW-1:0] cur_flags,
  input  logic          cur_emu,
  input  logic          valid,
  input  logic [2:0]    code,
  input  logic [FW-1:0] arg,
  input  cmp_flags_t    cmp,
  output logic [FW-1:0] nxt_flags,
  output logic          nxt_emu,
  output logic          load_en
);
  localparam int unsigned IW = $clog2(FW);

  logic [FW-1:0] raw;
  logic [FW-1:0] onehot;
  logic          raw_emu;

  always_comb begin
    onehot  = FW'(1) << arg[IW-1:0];
    raw     = cur_flags;
    raw_emu = cur_emu;
    load_en = valid && (code != CMD_IDLE);
    case (sfu_cmd_e'(code))
      CMD_CLRM: raw = cur_flags & ~arg;
      CMD_SETM: raw = cur_flags | arg;
      CMD_BCLR: raw = cur_flags & ~onehot;
      CMD_BSET: raw = cur_flags | onehot;
      CMD_XCHG: begin
        raw[B_CARRY] = cur_emu;
        raw_emu      = cur_flags[B_CARRY];
      end
      CMD_CMP: begin
        raw[B_NEG]   = cmp.neg;
        raw[B_ZERO]  = cmp.zero;
        raw[B_CARRY] = cmp.carry;
      end
      default: load_en = 1'b0;
    endcase
    nxt_emu   = raw_emu;
    nxt_flags = raw_emu ? (raw | EMU_FORCE) : raw;
  end
endmodule

// File: rtl/sfu_top.sv
module sfu_top
  import sfu_pkg::*;
#(
  parameter int unsigned FW = FLAG_W,
  parameter int unsigned W  = WORD_W,
  parameter int unsigned NW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [FW-1:0] cmd_arg,
  input  logic [W-1:0]  cmp_reg,
  input  logic [W-1:0]  cmp_mem,
  output logic [FW-1:0] status,
  output logic          emu,
  output logic          acc_wide,
  output logic          idx_wide,
  output logic          brk_flag
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [FW-1:0] flags_q, flags_d;
  logic          emu_q, emu_d;
  logic          load_en;
  cmp_flags_t    cmp_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sfu_compare #(.W(W), .NW(NW)) u_cmp (
    .reg_val (cmp_reg),
    .mem_val (cmp_mem),
    .narrow  (flags_q[B_ISZ]),
    .flags   (cmp_res)
  );

  sfu_next #(.FW(FW)) u_next (
    .cur_flags (flags_q),
    .cur_emu   (emu_q),
    .valid     (cmd_valid),
    .code      (cmd_code),
    .arg       (cmd_arg),
    .cmp       (cmp_res),
    .nxt_flags (flags_d),
    .nxt_emu   (emu_d),
    .load_en   (load_en)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flags_q <= RESET_FLAGS;
      emu_q   <= 1'b1;
    end else if (load_en) begin
      flags_q <= flags_d;
      emu_q   <= emu_d;
    end
  end

  assign status   = flags_q;
  assign emu      = emu_q;
  assign acc_wide = ~flags_q[B_ASZ];
  assign idx_wide = ~flags_q[B_ISZ] & ~emu_q;
  assign brk_flag = emu_q & flags_q[B_ISZ];

  // R5: emulation holds both sizes at 8 bits
  a_r5_emu_forces_sizes: assert property (@(posedge clk) disable iff (!rst_int_n)
    emu |-> (status[B_ASZ] && status[B_ISZ]));

  // R9: no accepted command, no change
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cmd_valid || cmd_code == 3'd0) |=> ($stable(status) && $stable(emu)));

  // R2: masked set reaches every selected bit
  a_r2_set_mask: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_code == 3'd2) |=> ((status & $past(cmd_arg)) == $past(cmd_arg)));

  // R2: masked clear reaches every selected bit not forced by emulation
  a_r2_clear_mask: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_code == 3'd1) |=>
      ((status & $past(cmd_arg) & (emu ? ~EMU_FORCE : {FW{1'b1}})) == '0));

  // R5: swap exchanges carry and emulation
  a_r5_swap: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_code == 3'd5) |=>
      (emu == $past(status[B_CARRY]) && status[B_CARRY] == $past(emu)));

  // R6: compare carry is a magnitude test at the width in force
  a_r6_cmp_carry: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_code == 3'd6) |=>
      (status[B_CARRY] == ($past(status[B_ISZ]) ?
         ($past(cmp_reg[NW-1:0]) >= $past(cmp_mem[NW-1:0])) :
         ($past(cmp_reg) >= $past(cmp_mem)))));

  // R6: compare leaves V, D, I untouched
  a_r6_cmp_keeps_others: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_valid && cmd_code == 3'd6) |=>
      (status[B_OVF] == $past(status[B_OVF]) && status[B_DEC] == $past(status[B_DEC])
       && status[B_IRQ] == $past(status[B_IRQ]) && $stable(emu)));
endmodule

// File: tb/tb_sfu_top.sv
module tb_sfu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [7:0]  cmd_arg = 8'h00;
  logic [15:0] cmp_reg = 16'h0;
  logic [15:0] cmp_mem = 16'h0;
  logic [7:0]  status;
  logic        emu, acc_wide, idx_wide, brk_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfu_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_arg(cmd_arg), .cmp_reg(cmp_reg), .cmp_mem(cmp_mem),
    .status(status), .emu(emu), .acc_wide(acc_wide), .idx_wide(idx_wide),
    .brk_flag(brk_flag)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [7:0] ef, logic ee, logic eaw, logic eiw, logic eb);
    chk(req, "status", 16'(status), 16'(ef));
    chk(req, "emu", 16'(emu), 16'(ee));
    chk(req, "acc_wide", 16'(acc_wide), 16'(eaw));
    chk(req, "idx_wide", 16'(idx_wide), 16'(eiw));
    chk(req, "brk_flag", 16'(brk_flag), 16'(eb));
  endtask

  // drive at negedge, one edge accepts, sample at next negedge
  task automatic issue(logic v, logic [2:0] c, logic [7:0] a, logic [15:0] r, logic [15:0] m);
    @(negedge clk);
    cmd_valid = v; cmd_code = c; cmd_arg = a; cmp_reg = r; cmp_mem = m;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0;
  endtask

  task automatic t_reset();
    chk_state("R1", 8'h30, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4", "brk in emulation", 16'(brk_flag), 16'h1);
    chk("R3", "idx_wide in emulation", 16'(idx_wide), 16'h0);
  endtask

  task automatic t_single_bits();
    issue(1, 3'd4, 8'h00, 0, 0);
    chk("R8", "set C", 16'(status), 16'h31);
    issue(1, 3'd3, 8'h00, 0, 0);
    chk("R8", "clear C", 16'(status), 16'h30);
  endtask

  task automatic t_swap_to_native();
    issue(1, 3'd5, 8'h00, 0, 0);
    chk_state("R5", 8'h31, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4", "brk native", 16'(brk_flag), 16'h0);
  endtask

  task automatic t_go_wide();
    issue(1, 3'd1, 8'h30, 0, 0);
    chk_state("R2", 8'h01, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3", "both wide", {14'h0, acc_wide, idx_wide}, 16'h3);
  endtask

  task automatic t_cmp_wide();
    issue(1, 3'd6, 8'h00, 16'h1234, 16'h1234);
    chk("R6", "wide equal", 16'(status), 16'h03);
    issue(1, 3'd6, 8'h00, 16'h0100, 16'h0200);
    chk("R6", "wide less", 16'(status), 16'h80);
  endtask

  task automatic t_narrow_same_edge();
    issue(1, 3'd2, 8'h10, 0, 0);
    chk("R7", "idx_wide after X set", 16'(idx_wide), 16'h0);
    chk("R7", "status after X set", 16'(status), 16'h90);
    chk("R3", "acc still wide", 16'(acc_wide), 16'h1);
  endtask

  task automatic t_cmp_narrow();
    issue(1, 3'd6, 8'h00, 16'h0100, 16'h0200);
    chk("R6", "narrow low bytes equal", 16'(status), 16'h13);
    issue(1, 3'd6, 8'h00, 16'h0005, 16'h0010);
    chk("R6", "narrow less", 16'(status), 16'h90);
  endtask

  task automatic t_ignored();
    issue(0, 3'd2, 8'hFF, 0, 0);
    chk("R9", "valid low", 16'(status), 16'h90);
    issue(1, 3'd0, 8'hFF, 0, 0);
    chk("R9", "idle code", 16'(status), 16'h90);
    chk("R9", "emu held", 16'(emu), 16'h0);
  endtask

  task automatic t_masks();
    issue(1, 3'd2, 8'h41, 0, 0);
    chk("R2", "set V C", 16'(status), 16'hD1);
    issue(1, 3'd1, 8'hC0, 0, 0);
    chk("R2", "clear N V", 16'(status), 16'h11);
  endtask

  task automatic t_back_to_emu();
    issue(1, 3'd5, 8'h00, 0, 0);
    chk_state("R5", 8'h30, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(1, 3'd1, 8'hFF, 0, 0);
    chk("R5", "sizes forced after clear", 16'(status), 16'h30);
    chk("R4", "brk after clear", 16'(brk_flag), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_bits();
    t_swap_to_native();
    t_go_wide();
    t_cmp_wide();
    t_narrow_same_edge();
    t_cmp_narrow();
    t_ignored();
    t_masks();
    t_back_to_emu();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule